// File: doc/BRIEF.md
# Burst Line-Fill Memory Responder

This block is the memory side of a cache-line fill. A requester asserts its address strobe with a read address and, if it wants a whole line, a burst-request line. The requester keeps that address unchanged for the whole cycle. The responder therefore keeps its own long-word index. The index starts at the address bits 3:2 presented on the bus and steps by one per beat, modulo four. The line address above bit 3 stays frozen. Each long word comes from an internal synchronous array and is announced by a one-clock termination strobe.

When a burst starts part-way into a 16-byte line, a static mode input decides what happens at index 3. In stop mode the burst ends at index 3. In wrap mode the index wraps to 0 and the burst goes on until four long words have been sent. The burst-acknowledge output tells the requester that another beat will follow. A read without burst request is served as one single transfer. Write cycles are not answered.

Top module: `burst_fill_responder`

## Requirements
- R1: While reset is high and in the first cycle after it, term_strobe and burst_ack are 0 and rd_data is 0.
- R2: The first term_strobe of a read cycle is high FIRST_WAIT+1 clocks after the clock edge that first samples addr_strobe=1 with rd_wr=1.
- R3: Each later beat's term_strobe is high LATER_WAIT+1 clocks after the previous one. Each strobe lasts one clock when LATER_WAIT>0.
- R4: Beat k of a cycle with start address a returns the word at line a[ADDR_W-1:4] and index (a[3:2]+k) mod 4. Word address w holds the value {16'hC0DE, w[15:0]}. rd_data changes only together with term_strobe.
- R5: If burst_req is 0 at the first beat, exactly one beat is sent and burst_ack stays 0.
- R6: In stop mode (wrap_mode=0), a burst that starts at index s sends 4-s beats. The beat at index 3 is the last one.
- R7: In wrap mode (wrap_mode=1), a burst sends exactly four beats and wraps the index from 3 to 0.
- R8: burst_ack is high only together with term_strobe, and exactly on beats that are followed by another beat.
- R9: If burst_req is 0 at the edge that issues a later beat, that beat is the last one.
- R10: Once addr_strobe is sampled 0, term_strobe and burst_ack are 0 from the next cycle. No more beats of that cycle appear, and a new cycle can start.
- R11: A cycle with rd_wr=0 produces no term_strobe and no burst_ack.
- R12: A burst starting at index 0 sends the same four beats in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_strobe | input | 1 | Requester cycle valid, active high |
| addr | input | ADDR_W | Byte address, held constant for the cycle |
| burst_req | input | 1 | Requester asks for (more) burst beats |
| rd_wr | input | 1 | 1 = read, 0 = write |
| wrap_mode | input | 1 | 1 = wrap past index 3, 0 = stop at index 3 |
| burst_ack | output | 1 | Another beat follows this one |
| term_strobe | output | 1 | One-clock pulse marking a valid data beat |
| rd_data | output | 32 | Long word of the current beat |

## Verification
A wrong index counter shows up on the very next beat. The word returned carries its own word address in the low half, so a skipped step, a lost wrap or a drifting line address gives the wrong value at once. A faulty beat count or a bad stop-mode decision shows in burst_ack on the beat before the error, and as an extra or missing strobe a few clocks later. A wait counter off by one moves a strobe by a clock, and the bench times every beat against the cycle start.

// File: rtl/bfr_pkg.sv
package bfr_pkg;

    localparam int unsigned LINE_WORDS = 4;
    localparam int unsigned BEAT_CNT_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } bfr_state_e;

    typedef struct packed {
        logic        strobe;
        logic        ack;
        logic [1:0]  idx;
    } beat_out_t;

    function automatic logic [31:0] fill_word(input int unsigned w);
        logic [31:0] wv;
        wv = w;
        return {16'hC0DE, wv[15:0]};
    endfunction

endpackage

// File: rtl/bfr_lw_counter.sv
module bfr_lw_counter
    import bfr_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [1:0]              start_idx,
    input  logic                    step,
    output logic [1:0]              idx,
    output logic [BEAT_CNT_W-1:0]   beats_sent
);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx        <= 2'd0;
            beats_sent <= '0;
        end else if (load) begin
            idx        <= start_idx;
            beats_sent <= '0;
        end else if (step) begin
            idx        <= idx + 2'd1;
            beats_sent <= beats_sent + 1'b1;
        end
    end

endmodule

// File: rtl/bfr_wait_timer.sv
module bfr_wait_timer #(
    parameter int unsigned FIRST_WAIT = 2,
    parameter int unsigned LATER_WAIT = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic load_first,
    input  logic load_later,
    output logic expired
);

    localparam int unsigned MAXW = (FIRST_WAIT > LATER_WAIT) ? FIRST_WAIT : LATER_WAIT;
    localparam int unsigned CW   = (MAXW < 2) ? 1 : $clog2(MAXW + 1);
    localparam logic [CW-1:0] FW_V = CW'(FIRST_WAIT);
    localparam logic [CW-1:0] LW_V = CW'(LATER_WAIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load_first) cnt <= FW_V;
        else if (load_later) cnt <= LW_V;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/bfr_line_store.sv
module bfr_line_store
    import bfr_pkg::*;
#(
    parameter int unsigned WORD_AW = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic [WORD_AW-1:0] rd_addr,
    output logic [31:0]        rd_data
);

    localparam int unsigned DEPTH = 1 << WORD_AW;

    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= fill_word(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/burst_fill_responder.sv
module burst_fill_responder
    import bfr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned FIRST_WAIT = 2,
    parameter int unsigned LATER_WAIT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_strobe,
    input  logic [ADDR_W-1:0] addr,
    input  logic              burst_req,
    input  logic              rd_wr,
    input  logic              wrap_mode,
    output logic              burst_ack,
    output logic              term_strobe,
    output logic [31:0]       rd_data
);

    localparam int unsigned WORD_AW = ADDR_W - 2;
    localparam int unsigned LINE_W  = ADDR_W - 4;
    localparam logic [BEAT_CNT_W-1:0] LAST_BEAT = BEAT_CNT_W'(LINE_WORDS - 1);

    bfr_state_e        state, state_nx;
    logic [LINE_W-1:0] line_q;
    logic [1:0]        idx;
    logic [BEAT_CNT_W-1:0] beats_sent;
    logic              start, issue, more, timer_zero;
    beat_out_t         out_q;
    logic [1:0]        dlv_idx;

    assign start = (state == ST_IDLE) && addr_strobe && rd_wr;
    assign issue = (state == ST_WAIT) && addr_strobe && timer_zero;
    assign more  = burst_req && (beats_sent < LAST_BEAT) && !(!wrap_mode && idx == 2'd3);

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (start) state_nx = ST_WAIT;
            ST_WAIT: begin
                if (!addr_strobe)      state_nx = ST_IDLE;
                else if (issue && !more) state_nx = ST_DONE;
            end
            ST_DONE: if (!addr_strobe) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            line_q <= '0;
            out_q  <= '0;
        end else begin
            state <= state_nx;
            if (start) line_q <= addr[ADDR_W-1:4];
            out_q.strobe <= issue;
            out_q.ack    <= issue && more;
            if (issue) out_q.idx <= idx;
        end
    end

    assign dlv_idx = out_q.idx;

    bfr_lw_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load       (start),
        .start_idx  (addr[3:2]),
        .step       (issue),
        .idx        (idx),
        .beats_sent (beats_sent)
    );

    bfr_wait_timer #(
        .FIRST_WAIT (FIRST_WAIT),
        .LATER_WAIT (LATER_WAIT)
    ) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .load_first (start),
        .load_later (issue),
        .expired    (timer_zero)
    );

    bfr_line_store #(
        .WORD_AW (WORD_AW)
    ) u_mem (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (issue),
        .rd_addr ({line_q, idx}),
        .rd_data (rd_data)
    );

    assign term_strobe = out_q.strobe;
    assign burst_ack   = out_q.ack;

endmodule

// File: rtl/bfr_checker.sv
module bfr_checker (
    input logic        clk,
    input logic        rst,
    input logic        addr_strobe,
    input logic        wrap_mode,
    input logic        burst_ack,
    input logic        term_strobe,
    input logic [31:0] rd_data,
    input logic [1:0]  dlv_idx
);

    logic [2:0] seen;

    always_ff @(posedge clk) begin
        if (rst || !addr_strobe) seen <= '0;
        else if (term_strobe)    seen <= seen + 3'd1;
    end

    p_ack_with_beat_r8: assert property (@(posedge clk) disable iff (rst)
        burst_ack |-> term_strobe);

    p_quiet_after_release_r10: assert property (@(posedge clk) disable iff (rst)
        !addr_strobe |=> (!term_strobe && !burst_ack));

    p_max_four_beats_r7: assert property (@(posedge clk) disable iff (rst)
        term_strobe |-> (seen < 3'd4));

    p_stop_at_three_r6: assert property (@(posedge clk) disable iff (rst)
        (term_strobe && !wrap_mode && dlv_idx == 2'd3) |-> !burst_ack);

    p_data_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !term_strobe |-> $stable(rd_data));

endmodule

bind burst_fill_responder bfr_checker u_bfr_chk (
    .clk         (clk),
    .rst         (rst),
    .addr_strobe (addr_strobe),
    .wrap_mode   (wrap_mode),
    .burst_ack   (burst_ack),
    .term_strobe (term_strobe),
    .rd_data     (rd_data),
    .dlv_idx     (dlv_idx)
);

// File: tb/test_burst_fill_responder.sv
module test_burst_fill_responder;

    localparam int FW = 2;
    localparam int LW = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_strobe = 1'b0;
    logic [7:0]  addr = '0;
    logic        burst_req = 1'b0;
    logic        rd_wr = 1'b1;
    logic        wrap_mode = 1'b0;
    logic        burst_ack;
    logic        term_strobe;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    burst_fill_responder #(.ADDR_W(8), .FIRST_WAIT(FW), .LATER_WAIT(LW)) i_burst_fill_responder (
        .clk(clk), .rst(rst), .addr_strobe(addr_strobe), .addr(addr),
        .burst_req(burst_req), .rd_wr(rd_wr), .wrap_mode(wrap_mode),
        .burst_ack(burst_ack), .term_strobe(term_strobe), .rd_data(rd_data));

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] word_at(input logic [3:0] line, input logic [1:0] ix);
        return {16'hC0DE, 10'd0, line, ix};
    endfunction

    // One read cycle; drop_at >= 1 names the beat that burst_req removal makes last (0 = never)
    task automatic run_read(input logic [7:0] a, input logic wm, input logic req,
                            input int drop_at, input string req_tag);
        int s, n, k, c0, last_c;
        s = int'(a[3:2]);
        if (!req)    n = 1;
        else if (wm) n = 4;
        else         n = 4 - s;
        if (drop_at > 0 && drop_at + 1 < n) n = drop_at + 1;
        @(negedge clk);
        addr = a; wrap_mode = wm; burst_req = req; rd_wr = 1'b1; addr_strobe = 1'b1;
        c0 = cyc; last_c = cyc; k = 0;
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            if (term_strobe) begin
                if (k == 0)
                    chk(cyc - c0 == FW + 2, "R2", "first beat delay", cyc - c0, FW + 2);
                else
                    chk(cyc - last_c == LW + 1, "R3", "beat spacing", cyc - last_c, LW + 1);
                chk(rd_data == word_at(a[7:4], 2'(s + k)), "R4", {req_tag, " beat data"},
                    rd_data, word_at(a[7:4], 2'(s + k)));
                chk(burst_ack == (k < n - 1), "R8", {req_tag, " ack on beat"},
                    burst_ack, (k < n - 1));
                last_c = cyc;
                if (drop_at > 0 && k == drop_at - 1) burst_req = 1'b0;
                k++;
            end else begin
                chk(!burst_ack, "R8", "ack without strobe", burst_ack, 0);
            end
        end
        chk(k == n, req_tag, "beat count", k, n);
        addr_strobe = 1'b0; burst_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!term_strobe && !burst_ack, "R10", "outputs after release",
            {term_strobe, burst_ack}, 0);
    endtask

    task automatic test_reset();
        chk(!term_strobe && !burst_ack && rd_data == 0, "R1", "outputs in reset",
            {term_strobe, burst_ack}, 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk(!term_strobe && !burst_ack && rd_data == 0, "R1", "outputs after reset",
            rd_data, 0);
    endtask

    task automatic test_write_ignored();
        int hits = 0;
        @(negedge clk);
        addr = 8'h34; rd_wr = 1'b0; burst_req = 1'b1; addr_strobe = 1'b1;
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            if (term_strobe || burst_ack) hits++;
        end
        chk(hits == 0, "R11", "write cycle answered", hits, 0);
        addr_strobe = 1'b0; burst_req = 1'b0; rd_wr = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_abort();
        int hits = 0;
        @(negedge clk);
        addr = 8'h98; wrap_mode = 1'b1; burst_req = 1'b1; rd_wr = 1'b1; addr_strobe = 1'b1;
        while (!term_strobe) @(negedge clk);
        addr_strobe = 1'b0;
        @(negedge clk);
        for (int t = 0; t < 15; t++) begin
            @(negedge clk);
            if (term_strobe || burst_ack) hits++;
        end
        chk(hits == 0, "R10", "beats after abort", hits, 0);
        burst_req = 1'b0;
        run_read(8'h58, 1'b1, 1'b1, 0, "R10");
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        run_read(8'h24, 1'b0, 1'b0, 0, "R5");   // single transfer
        run_read(8'h18, 1'b0, 1'b1, 0, "R6");   // stop mode, start index 2
        run_read(8'h4C, 1'b0, 1'b1, 0, "R6");   // stop mode, start index 3
        run_read(8'h74, 1'b1, 1'b1, 0, "R7");   // wrap mode, start index 1
        run_read(8'hEC, 1'b1, 1'b1, 0, "R7");   // wrap mode, start index 3
        run_read(8'h30, 1'b0, 1'b1, 0, "R12");  // index 0, stop mode
        run_read(8'h30, 1'b1, 1'b1, 0, "R12");  // index 0, wrap mode
        run_read(8'hA4, 1'b1, 1'b1, 2, "R9");   // request removed, beat 2 last
        test_write_ignored();
        test_abort();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule